// File: doc/BRIEF.md
# BCD Clock and Calendar Counter

This block keeps wall-clock time and calendar date as a chain of BCD counters: seconds, minutes, hours, day of week, day of month, month and two-digit year, plus a century bit. Each field advances when the field below it wraps. The whole chain moves by one second on each cycle where the one-cycle `tick_1hz` enable is high. Hours are kept either in 24-hour form or in 12-hour form with a PM flag. The format is chosen by a bit inside the hour byte itself. The last day of each month follows the month number and a divide-by-four leap rule.

Every field is always visible on its own output port. A parallel write port loads one field per cycle, chosen by a 3-bit field select. The block does not check that a written value is a legal time or date. Holding `chain_stop` high freezes the counting, while writes still take effect. This lets software load a full time and date without the count moving under it.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count 0x00 to 0x59 in BCD, one step per tick. The seconds field steps from 0x59 to 0x00 and advances minutes in the same cycle. The minutes field steps from 0x59 to 0x00 and advances hours in the same cycle.
- R2: When hour bit 6 is 0 (24-hour form), hours count 0x00 to 0x23 in BCD. The step from 0x23 to 0x00 advances both day of week and day of month.
- R3: When hour bit 6 is 1 (12-hour form), bit 5 is the PM flag and bits 4:0 hold BCD 01 to 12. The order is 12, 01, … 11. PM toggles on the 11-to-12 step, so 12 AM is 0x52 and 12 PM is 0x72. Only the step from 11 PM to 12 AM advances the day.
- R4: Day of week counts 1 to 7 and then returns to 1.
- R5: Day of month wraps to 0x01 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. The wrap advances the month.
- R6: In month 2, day of month wraps after 29 when the year is divisible by 4 (00 included), and after 28 otherwise.
- R7: The month (bits 4:0 of the month byte) counts 01 to 12 in BCD. The step from 12 to 01 advances the year. The year counts 0x00 to 0x99.
- R8: Bit 7 of the month byte is a century bit. It toggles in the cycle the year steps from 0x99 to 0x00.
- R9: While `chain_stop` is 1, ticks change no field. Writes are still applied.
- R10: A write with `wr_en` = 1 loads `wr_data` into the field chosen by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. The new value appears after the next clock edge. A tick in that cycle is dropped for the written field, and the written field passes no carry upward in that cycle. Fields below it still count. `wr_sel` = 7 changes nothing.
- R11: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour form), day of week 0x01, day of month 0x01, month 0x01 with century 0, and year 0x00.
- R12: In a cycle with no tick and no write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle enable, advance by one second |
| chain_stop | input | 1 | 1 freezes counting |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Value loaded into the selected field |
| t_sec | output | 8 | Seconds, BCD |
| t_min | output | 8 | Minutes, BCD |
| t_hour | output | 8 | Hours: bit 6 format, bit 5 PM in 12-hour form |
| t_wday | output | 8 | Day of week 1 to 7 |
| t_date | output | 8 | Day of month, BCD |
| t_month | output | 8 | Bit 7 century, bits 4:0 month BCD |
| t_year | output | 8 | Year, BCD |

## Verification
A field write and a tick can land in the same cycle, and that collision is the main corner case. The bench places a tick on the same clock edge as a write:
- to seconds while seconds sit at 59, which must cost the minute its carry;
- to minutes while seconds wrap, where the carry must be absorbed by the write.

Each case is judged by reading every neighbouring field after the edge. The full hour sequence in both formats and every month end across leap, non-leap and century years are swept. Expected values come from arithmetic in the bench.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = $clog2(NUM_FIELDS + 1);

  typedef enum logic [SEL_W-1:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_WDAY = 3'd3,
    F_DATE = 3'd4, F_MONTH = 3'd5, F_YEAR = 3'd6
  } field_e;

  typedef struct packed {
    logic [7:0] value;
    logic       carry;
  } hour_step_t;

  // Increment a two-digit BCD value (no upper bound handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [3:0] lo, hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo == 4'd9) return {hi + 4'd1, 4'd0};
    return {hi, lo + 4'd1};
  endfunction

  function automatic int unsigned bcd_to_int(input logic [7:0] v);
    return 32'(v[7:4]) * 10 + 32'(v[3:0]);
  endfunction

  function automatic logic year_is_leap(input logic [7:0] yr_bcd);
    int unsigned y;
    y = bcd_to_int(yr_bcd);
    return (y % 4) == 0;
  endfunction

  // Last day of the month in BCD.
  function automatic logic [7:0] month_last(input logic [4:0] mon_bcd, input logic leap);
    int unsigned m;
    m = bcd_to_int({3'b000, mon_bcd});
    if (m == 2) return leap ? 8'h29 : 8'h28;
    return ((m % 2 == 1) ^ (m >= 8)) ? 8'h31 : 8'h30;
  endfunction

  // Next hour byte and day carry, both formats.
  function automatic hour_step_t hour_next(input logic [7:0] h);
    hour_step_t r;
    r.value = h;
    r.carry = 1'b0;
    if (h[6]) begin
      if (h[4:0] == 5'h12) begin
        r.value = {h[7:5], 5'h01};
      end else if (h[4:0] == 5'h11) begin
        r.value = {h[7:6], ~h[5], 5'h12};
        r.carry = h[5];
      end else begin
        r.value = {h[7:5], bcd_inc({3'b000, h[4:0]})[4:0]};
      end
    end else begin
      if (h[5:0] == 6'h23) begin
        r.value = {h[7:6], 6'h00};
        r.carry = 1'b1;
      end else begin
        r.value = {h[7:6], bcd_inc({2'b00, h[5:0]})[5:0]};
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
#(
  parameter int W = FIELD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         wr_sec,
  input  logic         wr_min,
  input  logic         wr_hour,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] sec_q,
  output logic [W-1:0] min_q,
  output logic [W-1:0] hour_q,
  output logic         sec_wrap,
  output logic         min_wrap,
  output logic         day_adv
);
  localparam logic [W-1:0] LAST_MS = W'(8'h59);

  logic       step_sec, step_min, step_hour;
  hour_step_t hnext;

  assign hnext     = hour_next(hour_q);
  assign step_sec  = step & ~wr_sec;
  assign sec_wrap  = step_sec & (sec_q == LAST_MS);
  assign step_min  = sec_wrap & ~wr_min;
  assign min_wrap  = step_min & (min_q == LAST_MS);
  assign step_hour = min_wrap & ~wr_hour;
  assign day_adv   = step_hour & hnext.carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else begin
      if (wr_sec)        sec_q <= wr_data;
      else if (sec_wrap) sec_q <= '0;
      else if (step_sec) sec_q <= bcd_inc(sec_q);

      if (wr_min)        min_q <= wr_data;
      else if (min_wrap) min_q <= '0;
      else if (step_min) min_q <= bcd_inc(min_q);

      if (wr_hour)        hour_q <= wr_data;
      else if (step_hour) hour_q <= hnext.value;
    end
  end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
#(
  parameter int W = FIELD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         day_adv,
  input  logic         wr_wday,
  input  logic         wr_date,
  input  logic         wr_month,
  input  logic         wr_year,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] wday_q,
  output logic [W-1:0] date_q,
  output logic [W-1:0] month_q,
  output logic [W-1:0] year_q,
  output logic         date_wrap,
  output logic         month_wrap,
  output logic         year_wrap
);
  localparam logic [W-1:0] ONE      = W'(1);
  localparam logic [W-1:0] LAST_WD  = W'(7);
  localparam logic [4:0]   LAST_MON = 5'h12;
  localparam logic [W-1:0] LAST_YR  = W'(8'h99);

  logic       step_wday, step_date, step_mon, step_yr;
  logic [7:0] last_day;

  assign last_day   = month_last(month_q[4:0], year_is_leap(year_q));
  assign step_wday  = day_adv & ~wr_wday;
  assign step_date  = day_adv & ~wr_date;
  assign date_wrap  = step_date & (date_q == last_day);
  assign step_mon   = date_wrap & ~wr_month;
  assign month_wrap = step_mon & (month_q[4:0] == LAST_MON);
  assign step_yr    = month_wrap & ~wr_year;
  assign year_wrap  = step_yr & (year_q == LAST_YR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday_q  <= ONE;
      date_q  <= ONE;
      month_q <= ONE;
      year_q  <= '0;
    end else begin
      if (wr_wday)        wday_q <= wr_data;
      else if (step_wday) wday_q <= (wday_q == LAST_WD) ? ONE : wday_q + ONE;

      if (wr_date)        date_q <= wr_data;
      else if (date_wrap) date_q <= ONE;
      else if (step_date) date_q <= bcd_inc(date_q);

      if (wr_month)        month_q <= wr_data;
      else if (month_wrap) month_q <= {month_q[7] ^ year_wrap, 2'b00, 5'h01};
      else if (step_mon)   month_q <= {month_q[7:5], bcd_inc({3'b000, month_q[4:0]})[4:0]};

      if (wr_year)        year_q <= wr_data;
      else if (year_wrap) year_q <= '0;
      else if (step_yr)   year_q <= bcd_inc(year_q);
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       chain_stop,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] t_sec,
  output logic [7:0] t_min,
  output logic [7:0] t_hour,
  output logic [7:0] t_wday,
  output logic [7:0] t_date,
  output logic [7:0] t_month,
  output logic [7:0] t_year
);
  logic [NUM_FIELDS-1:0] wr_hit;
  logic step, sec_wrap, min_wrap, day_adv, date_wrap, month_wrap, year_wrap;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wdec
    assign wr_hit[i] = wr_en && (wr_sel == SEL_W'(i));
  end

  assign step = tick_1hz & ~chain_stop;

  rtc_time_chain #(.W(FIELD_W)) u_time (
    .clk, .rst_n, .step,
    .wr_sec(wr_hit[F_SEC]), .wr_min(wr_hit[F_MIN]), .wr_hour(wr_hit[F_HOUR]),
    .wr_data,
    .sec_q(t_sec), .min_q(t_min), .hour_q(t_hour),
    .sec_wrap, .min_wrap, .day_adv
  );

  rtc_date_chain #(.W(FIELD_W)) u_date (
    .clk, .rst_n, .day_adv,
    .wr_wday(wr_hit[F_WDAY]), .wr_date(wr_hit[F_DATE]),
    .wr_month(wr_hit[F_MONTH]), .wr_year(wr_hit[F_YEAR]),
    .wr_data,
    .wday_q(t_wday), .date_q(t_date), .month_q(t_month), .year_q(t_year),
    .date_wrap, .month_wrap, .year_wrap
  );
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       chain_stop,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] t_sec,
  input logic [7:0] t_min,
  input logic [7:0] t_hour,
  input logic [7:0] t_wday,
  input logic [7:0] t_date,
  input logic [7:0] t_month,
  input logic [7:0] t_year,
  input logic       sec_wrap,
  input logic       day_adv,
  input logic       year_wrap
);
  logic [55:0] all_f;
  assign all_f = {t_sec, t_min, t_hour, t_wday, t_date, t_month, t_year};

  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !wr_en) |=> $stable(all_f));

  a_r9_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_stop && !wr_en) |=> $stable(all_f));

  a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> (t_sec == $past(wr_data)));

  a_r10_no_carry_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> $stable(t_min));

  a_r1_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !(wr_en && wr_sel == 3'd1)) |=> (t_sec == 8'h00 && t_min != $past(t_min)));

  a_r4_day_moves_wday: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && !wr_en) |=> (t_wday != $past(t_wday)));

  a_r8_century_flip: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> (t_year == 8'h00 && t_month[7] != $past(t_month[7])));
endmodule

bind rtc_calendar_core rtc_calendar_checker u_chk (
  .clk, .rst_n, .tick_1hz, .chain_stop, .wr_en, .wr_sel, .wr_data,
  .t_sec, .t_min, .t_hour, .t_wday, .t_date, .t_month, .t_year,
  .sec_wrap, .day_adv, .year_wrap
);

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0, chain_stop = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] t_sec, t_min, t_hour, t_wday, t_date, t_month, t_year;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_calendar_core u_rtc_calendar_core (.*);

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  // Hour index 0..23 to hour byte in the chosen form.
  function automatic logic [7:0] hour_enc(input int idx, input bit twelve);
    int h;
    if (!twelve) return to_bcd(idx);
    h = idx % 12;
    if (h == 0) h = 12;
    return 8'h40 | (idx >= 12 ? 8'h20 : 8'h00) | to_bcd(h);
  endfunction
  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic tk, input logic we, input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    tick_1hz = tk; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    tick_1hz = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    drive(1'b0, 1'b1, sel, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset values
    chk("R11 sec", t_sec, 8'h00);   chk("R11 min", t_min, 8'h00);
    chk("R11 hour", t_hour, 8'h00); chk("R11 wday", t_wday, 8'h01);
    chk("R11 date", t_date, 8'h01); chk("R11 month", t_month, 8'h01);
    chk("R11 year", t_year, 8'h00);

    // R12 idle cycles hold
    repeat (5) @(negedge clk);
    chk("R12 hold sec", t_sec, 8'h00);

    // R1 full minute of seconds
    for (int s = 1; s <= 60; s++) begin
      drive(1'b1, 1'b0, 3'd0, 8'h00);
      chk("R1 sec count", t_sec, to_bcd(s % 60));
      chk("R1 min carry", t_min, (s == 60) ? 8'h01 : 8'h00);
    end
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    drive(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R1 min wrap", t_min, 8'h00);
    chk("R1 hour carry", t_hour, 8'h01);

    // R2 / R3 / R4 full hour sweep in both forms
    for (int f = 0; f < 2; f++) begin
      for (int idx = 0; idx < 24; idx++) begin
        int w;
        w = (idx == 23) ? 7 : (idx % 7 + 1);
        wr(3'd2, hour_enc(idx, f == 1));
        wr(3'd3, to_bcd(w));
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        drive(1'b1, 1'b0, 3'd0, 8'h00);
        chk(f == 1 ? "R3 hour step 12h" : "R2 hour step 24h",
            t_hour, hour_enc((idx + 1) % 24, f == 1));
        chk("R4 wday", t_wday, to_bcd(idx == 23 ? 1 : w));
        chk("R1 min zero", t_min, 8'h00);
      end
    end

    // R5 / R6 / R7 / R8 month ends across years
    for (int yi = 0; yi < 7; yi++) begin
      int yv;
      case (yi)
        0: yv = 0;  1: yv = 1;  2: yv = 2;  3: yv = 3;
        4: yv = 4;  5: yv = 96; default: yv = 99;
      endcase
      for (int m = 1; m <= 12; m++) begin
        int len;
        len = days_in(m, yv);
        wr(3'd6, to_bcd(yv));
        wr(3'd5, to_bcd(m));
        wr(3'd4, to_bcd(len - 1));
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        drive(1'b1, 1'b0, 3'd0, 8'h00);
        chk(m == 2 ? "R6 feb before end" : "R5 before end", t_date, to_bcd(len));
        chk("R5 month held", t_month, to_bcd(m));
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        drive(1'b1, 1'b0, 3'd0, 8'h00);
        chk(m == 2 ? "R6 feb wrap" : "R5 date wrap", t_date, 8'h01);
        chk("R7 month step", t_month,
            (m == 12 && yv == 99) ? 8'h81 : to_bcd(m == 12 ? 1 : m + 1));
        chk(yv == 99 ? "R8 year wrap" : "R7 year step", t_year,
            to_bcd(m == 12 ? (yv + 1) % 100 : yv));
      end
    end
    chk("R8 century stays", t_month[7:0], 8'h81);

    // R9 stop freezes counting, writes still go in
    wr(3'd0, 8'h10);
    @(negedge clk); chain_stop = 1'b1;
    for (int k = 0; k < 5; k++) drive(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R9 stopped", t_sec, 8'h10);
    drive(1'b1, 1'b1, 3'd0, 8'h22);
    chk("R9 write while stopped", t_sec, 8'h22);
    @(negedge clk); chain_stop = 1'b0;
    drive(1'b1, 1'b0, 3'd0, 8'h00);
    chk("R9 resumed", t_sec, 8'h23);

    // R10 write collides with tick
    wr(3'd1, 8'h10); wr(3'd0, 8'h59);
    drive(1'b1, 1'b1, 3'd0, 8'h30);
    chk("R10 sec written", t_sec, 8'h30);
    chk("R10 no carry", t_min, 8'h10);
    wr(3'd0, 8'h59);
    drive(1'b1, 1'b1, 3'd1, 8'h45);
    chk("R10 lower field counts", t_sec, 8'h00);
    chk("R10 carry absorbed", t_min, 8'h45);
    wr(3'd2, 8'h07);
    drive(1'b0, 1'b1, 3'd7, 8'h33);
    chk("R10 sel7 sec", t_sec, 8'h00); chk("R10 sel7 min", t_min, 8'h45);
    chk("R10 sel7 hour", t_hour, 8'h07); chk("R10 sel7 year", t_year, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule